// File: doc/BRIEF.md
# Serial Shift Unit with Edge Counter

This block is the data path of a general serial port. It is an eight-bit shift register paired with a four-bit counter that advances on every edge of a serial clock. Software loads the byte to send into the data register and clears the counter through the status register. Each serial clock cycle then shifts the register one place: the most significant bit is driven on the data output pin, and the data input pin fills the least significant bit. After sixteen edges, which is eight full clock cycles, the counter wraps and raises an overflow flag. Software polls that flag, and once it is set the received byte is in the data register.

The serial clock comes either from an external pin, which is synchronised into the core clock domain, or from a level that software toggles with a control register write. A control field picks whether shifting happens on the rising or the falling edge of that clock. The same field also picks the line style. Three-wire operation drives the output pin with a push-pull level. Two-wire operation pulls the shared data line low whenever the outgoing bit is zero, and in this style shifting on the falling edge is the practical choice.

Top module: `usu_core`

## Requirements
- R1: After synchronous reset the control, status and data registers all read 0, the serial clock source is the pin, `dout_pin` is 0 and `sda_low_o` is 0.
- R2: The register map is: address 0 control, address 1 status, address 2 data; address 3 reads 0. In control, bits [1:0] select the mode: 00 off, 01 three-wire, 10 or 11 two-wire. Bit 2 selects the clock source (0 pin, 1 software level). Bit 3 selects the shift edge (0 rising, 1 falling). Bit 4 is the toggle bit: it always reads 0, and writing it as 1 inverts the software level.
- R3: While the mode is not off, every rising or falling edge of the selected clock adds 1 to the four-bit counter, modulo 16.
- R4: The status register reads as {flag, 3'b000, counter}, with the flag in bit 7. An edge that takes the counter from 15 to 0 sets the flag, and the flag stays set until software clears it.
- R5: On each selected shift edge, when the mode is not off, the data register shifts left by one and the sampled data input enters bit 0. Edges of the other polarity leave it unchanged. After 16 edges starting from a count of 0, the register holds the eight input bits, first received in bit 7, and the flag is set.
- R6: A status write clears the flag when bit 7 is 1 and always loads bits [3:0] into the counter. If a clock edge arrives in the same cycle as the write, the load takes priority and that edge is not counted.
- R7: `dout_pin` always equals bit 7 of the data register. `sda_low_o` is 1 exactly when the mode is two-wire and bit 7 is 0.
- R8: A data write replaces the shift register at once, even in the middle of a transfer, and takes priority over a shift in the same cycle.
- R9: With the mode off, clock edges change neither the counter nor the data register.
- R10: With the software source selected, each toggle write makes exactly one clock edge, which is counted and shifted like an edge from the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational on `bus_addr` |
| sclk_pin | input | 1 | External serial clock, asynchronous |
| din_pin | input | 1 | Serial data input, asynchronous |
| dout_pin | output | 1 | Serial data output, bit 7 of the data register |
| sda_low_o | output | 1 | Two-wire mode: pull the shared data line low |

## Verification
The bench builds the block with its default widths: an eight-bit register, a four-bit counter and two synchroniser stages. At that size every possible transmit byte can be swept through a full pin-clocked transfer. For each of the 256 bytes, the bench checks the outgoing bit before every shift and checks the received byte against an arithmetic pattern. A shorter sweep runs in two-wire mode with software-toggled falling-edge shifting. Directed steps cover the following cases:
- the counter wrapping from 15 to 0,
- the flag staying set until cleared,
- edges ignored while the mode is off,
- a data write landing in the middle of a transfer.

// File: rtl/usu_pkg.sv
package usu_pkg;

    localparam int unsigned ADDR_W     = 2;
    localparam logic [1:0]  ADDR_CTRL  = 2'd0;
    localparam logic [1:0]  ADDR_STAT  = 2'd1;
    localparam logic [1:0]  ADDR_DATA  = 2'd2;
    localparam int unsigned TOGGLE_BIT = 4;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_3WIRE  = 2'b01,
        MODE_2WIRE  = 2'b10,
        MODE_2WIREB = 2'b11
    } mode_e;

    typedef struct packed {
        logic  fall_edge;
        logic  sw_source;
        mode_e mode;
    } ctrl_t;

    function automatic logic mode_active(input mode_e m);
        return m != MODE_OFF;
    endfunction

    function automatic logic mode_two_wire(input mode_e m);
        return m == MODE_2WIRE || m == MODE_2WIREB;
    endfunction

    function automatic ctrl_t ctrl_from_bits(input logic [3:0] b);
        ctrl_t c;
        c.mode      = mode_e'(b[1:0]);
        c.sw_source = b[2];
        c.fall_edge = b[3];
        return c;
    endfunction

endpackage

// File: rtl/usu_edge_det.sv
module usu_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_clk,
    input  logic pin_din,
    input  logic sw_level,
    input  logic use_sw,
    output logic edge_any,
    output logic edge_rise,
    output logic edge_fall,
    output logic din_sync
);
    logic [1:0] sync_q [SYNC_STAGES];
    logic       level;
    logic       level_prev_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[s] <= 2'b00;
            end else if (s == 0) begin
                sync_q[s] <= {pin_din, pin_clk};
            end else begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign level    = use_sw ? sw_level : sync_q[SYNC_STAGES-1][0];
    assign din_sync = sync_q[SYNC_STAGES-1][1];

    always_ff @(posedge clk) begin
        if (rst) level_prev_q <= 1'b0;
        else     level_prev_q <= level;
    end

    assign edge_rise = level & ~level_prev_q;
    assign edge_fall = ~level & level_prev_q;
    assign edge_any  = level ^ level_prev_q;
endmodule

// File: rtl/usu_counter.sv
module usu_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear_flag,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic advance;
    logic wrap;

    assign advance = enable && step && !load;
    assign wrap    = advance && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (advance) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (clear_flag) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/usu_shifter.sv
module usu_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift,
    input  logic              din,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/usu_core.sv
module usu_core
    import usu_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_pin,
    input  logic              din_pin,
    output logic              dout_pin,
    output logic              sda_low_o
);
    localparam int unsigned FLAG_BIT = DATA_W - 1;
    localparam int unsigned PAD_W    = DATA_W - CNT_W - 1;

    ctrl_t             ctrl_q;
    logic              sw_level_q;
    logic              we_ctrl, we_stat, we_data;
    logic              active;
    logic              edge_any, edge_rise, edge_fall, din_sync;
    logic              shift;
    logic [CNT_W-1:0]  count;
    logic              flag;
    logic [DATA_W-1:0] shreg;

    assign we_ctrl = bus_we && (bus_addr == ADDR_CTRL);
    assign we_stat = bus_we && (bus_addr == ADDR_STAT);
    assign we_data = bus_we && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= ctrl_from_bits(4'h0);
            sw_level_q <= 1'b0;
        end else if (we_ctrl) begin
            ctrl_q     <= ctrl_from_bits(bus_wdata[3:0]);
            sw_level_q <= sw_level_q ^ bus_wdata[TOGGLE_BIT];
        end
    end

    assign active = mode_active(ctrl_q.mode);
    assign shift  = active && (ctrl_q.fall_edge ? edge_fall : edge_rise);

    usu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_clk   (sclk_pin),
        .pin_din   (din_pin),
        .sw_level  (sw_level_q),
        .use_sw    (ctrl_q.sw_source),
        .edge_any  (edge_any),
        .edge_rise (edge_rise),
        .edge_fall (edge_fall),
        .din_sync  (din_sync)
    );

    usu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable     (active),
        .step       (edge_any),
        .load       (we_stat),
        .load_val   (bus_wdata[CNT_W-1:0]),
        .clear_flag (we_stat && bus_wdata[FLAG_BIT]),
        .count      (count),
        .flag       (flag)
    );

    usu_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift    (shift),
        .din      (din_sync),
        .load     (we_data),
        .load_val (bus_wdata),
        .q        (shreg)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            ADDR_STAT: bus_rdata = {flag, {PAD_W{1'b0}}, count};
            ADDR_DATA: bus_rdata = shreg;
            default:   bus_rdata = '0;
        endcase
    end

    assign dout_pin  = shreg[DATA_W-1];
    assign sda_low_o = mode_two_wire(ctrl_q.mode) && !shreg[DATA_W-1];
endmodule

// File: rtl/usu_core_chk.sv
module usu_core_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              active,
    input logic              edge_any,
    input logic              shift,
    input logic              we_stat,
    input logic              we_data,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic [DATA_W-1:0] shreg,
    input logic              din_sync
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        active && edge_any && !we_stat |=> count == CNT_W'($past(count) + 1'b1));

    p_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        active && edge_any && !we_stat && count == CNT_MAX |=> flag);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        flag && !(we_stat && wdata[DATA_W-1]) |=> flag);

    p_shift_r5: assert property (@(posedge clk) disable iff (rst)
        shift && !we_data |=> shreg == {$past(shreg[DATA_W-2:0]), $past(din_sync)});

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        we_stat && wdata[DATA_W-1] |=> !flag);

    p_load_count_r6: assert property (@(posedge clk) disable iff (rst)
        we_stat |=> count == $past(wdata[CNT_W-1:0]));

    p_data_load_r8: assert property (@(posedge clk) disable iff (rst)
        we_data |=> shreg == $past(wdata));

    p_idle_count_r9: assert property (@(posedge clk) disable iff (rst)
        !active && !we_stat |=> $stable(count));

    p_idle_data_r9: assert property (@(posedge clk) disable iff (rst)
        !active && !we_data |=> $stable(shreg));
endmodule

bind usu_core usu_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .edge_any (edge_any),
    .shift    (shift),
    .we_stat  (we_stat),
    .we_data  (we_data),
    .wdata    (bus_wdata),
    .count    (count),
    .flag     (flag),
    .shreg    (shreg),
    .din_sync (din_sync)
);

// File: tb/usu_core_tb.sv
module usu_core_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sclk_pin = 1'b0;
    logic       din_pin = 1'b0;
    logic       dout_pin;
    logic       sda_low_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usu_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk_pin  (sclk_pin),
        .din_pin   (din_pin),
        .dout_pin  (dout_pin),
        .sda_low_o (sda_low_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse();
        sclk_pin = 1'b1; settle(4);
        sclk_pin = 1'b0; settle(4);
    endtask

    task automatic sw_toggle(input logic [7:0] ctrl);
        wr(2'd0, ctrl | 8'h10);
        settle(2);
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == e, req, v, e);
    endtask

    function automatic logic [7:0] rx_pattern(input int tx);
        return 8'((tx * 37 + 11) & 255);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        settle(3);
        rst = 1'b0;
        settle(1);

        // R1 reset state; R2 address 3 reads 0
        expect_reg(2'd0, 8'h00, "R1 ctrl");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 data");
        expect_reg(2'd3, 8'h00, "R2 unused address");
        check(dout_pin == 1'b0, "R1 dout", dout_pin, 0);
        check(sda_low_o == 1'b0, "R1 sda_low", sda_low_o, 0);

        // R9 mode off ignores pin edges
        wr(2'd2, 8'h5A);
        din_pin = 1'b1;
        repeat (3) pin_pulse();
        expect_reg(2'd1, 8'h00, "R9 counter idle");
        expect_reg(2'd2, 8'h5A, "R9 data idle");
        din_pin = 1'b0;

        // R2 control readback, toggle bit reads 0
        wr(2'd0, 8'h01);
        expect_reg(2'd0, 8'h01, "R2 ctrl readback");

        // R3 each edge counts: 3 pulses = 6 edges
        wr(2'd2, 8'h00);
        repeat (3) pin_pulse();
        expect_reg(2'd1, 8'h06, "R3 edge count");

        // R6 load counter, R4 wrap and sticky flag
        wr(2'd1, 8'h0E);
        expect_reg(2'd1, 8'h0E, "R6 counter load");
        pin_pulse();
        expect_reg(2'd1, 8'h80, "R4 wrap sets flag");
        pin_pulse();
        expect_reg(2'd1, 8'h82, "R4 flag sticky");
        wr(2'd1, 8'h80);
        expect_reg(2'd1, 8'h00, "R6 flag clear");

        // R5 R7 three-wire, pin clock, rising shift: all 256 bytes
        for (int tx = 0; tx < 256; tx++) begin
            logic [7:0] txb;
            logic [7:0] rxb;
            txb = 8'(tx);
            rxb = rx_pattern(tx);
            wr(2'd2, txb);
            wr(2'd1, 8'h80);
            for (int i = 7; i >= 0; i--) begin
                din_pin = rxb[i];
                settle(4);
                check(dout_pin == txb[i], "R7 dout bit", dout_pin, txb[i]);
                check(sda_low_o == 1'b0, "R7 sda idle in three-wire", sda_low_o, 0);
                pin_pulse();
            end
            expect_reg(2'd2, rxb, "R5 received byte");
            expect_reg(2'd1, 8'h80, "R5 flag after 16 edges");
        end

        // R10 R5 R7 two-wire, software clock, falling shift
        wr(2'd0, 8'h0E);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] txb;
            logic [7:0] rxb;
            txb = 8'(k * 17);
            rxb = rx_pattern(k * 17 + 3);
            wr(2'd2, txb);
            wr(2'd1, 8'h80);
            for (int i = 7; i >= 0; i--) begin
                din_pin = rxb[i];
                settle(3);
                check(sda_low_o == !txb[i], "R7 sda pull", sda_low_o, !txb[i]);
                sw_toggle(8'h0E);
                if (i == 7) expect_reg(2'd2, txb, "R5 rising edge no shift");
                sw_toggle(8'h0E);
            end
            expect_reg(2'd2, rxb, "R10 received byte");
            expect_reg(2'd1, 8'h80, "R10 flag after 16 toggles");
        end

        // R8 data write mid-transfer
        wr(2'd2, 8'h3C);
        wr(2'd1, 8'h80);
        din_pin = 1'b1;
        settle(3);
        repeat (4) sw_toggle(8'h0E);
        expect_reg(2'd2, 8'hF3, "R8 pre-write shifts");
        wr(2'd2, 8'hC3);
        expect_reg(2'd2, 8'hC3, "R8 write replaces");
        din_pin = 1'b0;
        settle(3);
        repeat (2) sw_toggle(8'h0E);
        expect_reg(2'd2, 8'h86, "R8 shift continues");
        expect_reg(2'd1, 8'h06, "R8 count unaffected");

        // R9 software toggles with mode off
        wr(2'd0, 8'h04);
        repeat (2) sw_toggle(8'h04);
        expect_reg(2'd1, 8'h06, "R9 sw idle count");
        expect_reg(2'd2, 8'h86, "R9 sw idle data");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule